// File: doc/BRIEF.md
# Dual-Thread Low-Power State Coordinator

This block follows the idle state of two hardware threads that share one core and derives from them the power state of the whole package. Each thread runs its own small state machine: running, halted (light sleep), and two deeper sleep levels. A halted thread may also be held in a clock-stopped sub-state or a snoop-servicing sub-state, and it returns to the halted state afterwards rather than to running.

Wake events (system-management interrupt, init, non-maskable interrupt, maskable interrupt and internal interrupt message) bring a sleeping thread back to running. A per-thread synchronous reset forces a thread to running from any state. After a system-management interrupt has woken a halted thread, the resume pulse from the handler selects whether the thread stays running or goes back to halt. The package state is the shallowest state held by any thread. It is registered, so it follows the thread states by one clock.

Top module: `cstate_coord`

## Requirements
- R1: While `rst_ni` is low and after it is released, every thread state reads 0, the package state reads 0 and every snoop flag is low.
- R2: Thread state codes are 0 = running, 1 = halted, 2 = sleep level 2, 3 = sleep level 4, 4 = halted with clock stopped, 5 = halted servicing a snoop. A halt request in state 0 gives state 1 on the next clock.
- R3: A sleep request in state 0 or 1 gives state 2 when `sleep_deep_i` is 0 and state 3 when it is 1, and it wins over a simultaneous halt. Sleep and halt requests in states 2 and 3 are ignored.
- R4: Any wake event in state 1, 2 or 3 gives state 0 on the next clock. Wake events in state 0 have no effect.
- R5: A thread reset gives state 0 on the next clock from any state, and it wins over every other input.
- R6: Stop-clock in state 1 gives state 4. The thread stays in state 4 while stop-clock is held, ignoring wake events, and returns to state 1 on the clock after it is released.
- R7: A snoop request in state 1 gives state 5. The thread stays there until a snoop-done pulse and then returns to state 1. The thread's snoop flag is high exactly while it is in state 5.
- R8: A system-management interrupt that wakes a thread from state 1 arms a resume. The next resume pulse sends the thread to state 1 when `rsm_halt_i` is 1 and leaves it in state 0 when it is 0. A resume pulse that is not armed has no effect.
- R9: The package state is 0, 1, 2 or 3 (running, halted, level 2, level 4). It equals the shallowest thread state, with states 4 and 5 counted as halted, and it is updated one clock after the thread states.
- R10: In state 1 the priority is wake, then sleep request, then stop-clock, then snoop request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| thr_rst_i | input | NT | Per-thread synchronous reset |
| halt_i | input | NT | Halt request |
| sleep_req_i | input | NT | Deeper-sleep request |
| sleep_deep_i | input | NT | Sleep target: 0 = level 2, 1 = level 4 |
| smi_i | input | NT | System-management interrupt wake |
| init_i | input | NT | Init wake |
| nmi_i | input | NT | Non-maskable interrupt wake |
| intr_i | input | NT | Maskable interrupt wake |
| intmsg_i | input | NT | Internal interrupt message wake |
| rsm_i | input | NT | Resume pulse from the interrupt handler |
| rsm_halt_i | input | NT | Resume target: 1 = back to halt |
| stpclk_i | input | 1 | Stop-clock request |
| snoop_req_i | input | 1 | Snoop request |
| snoop_done_i | input | 1 | Snoop completion pulse |
| thr_state_o | output | 3*NT | Thread state codes, thread i at bits [3i+2:3i] |
| pkg_state_o | output | 2 | Resolved package state |
| snoop_busy_o | output | NT | Per-thread snoop-in-progress flag |

## Verification
The package resolution is driven through all sixteen pairs of base thread states, each built from a fresh thread reset. This separates a true minimum from a maximum, from a one-sided pick and from a resolution that is late by one cycle. The sub-states are driven on one thread while the other keeps running, so a shared stop-clock or snoop line that leaks into a running thread is caught. The resume path is tried armed and unarmed with both targets. The priority cases assert several C1 exits in the same cycle to expose a wrong ordering.

// File: rtl/cstate_pkg.sv
package cstate_pkg;
  typedef enum logic [2:0] {
    ST_C0     = 3'd0,
    ST_C1     = 3'd1,
    ST_C2     = 3'd2,
    ST_C4     = 3'd3,
    ST_C1_STP = 3'd4,
    ST_C1_SNP = 3'd5
  } thr_st_e;

  typedef enum logic [1:0] {
    PK_C0 = 2'd0,
    PK_C1 = 2'd1,
    PK_C2 = 2'd2,
    PK_C4 = 2'd3
  } pkg_st_e;

  // sub-states of the halted state count as halted
  function automatic pkg_st_e depth_of(thr_st_e s);
    case (s)
      ST_C0:   return PK_C0;
      ST_C2:   return PK_C2;
      ST_C4:   return PK_C4;
      default: return PK_C1;
    endcase
  endfunction
endpackage

// File: rtl/thread_fsm.sv
module thread_fsm
  import cstate_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    thr_rst_i,
  input  logic    halt_i,
  input  logic    sleep_req_i,
  input  logic    sleep_deep_i,
  input  logic    smi_i,
  input  logic    wake_i,
  input  logic    rsm_i,
  input  logic    rsm_halt_i,
  input  logic    stpclk_i,
  input  logic    snoop_req_i,
  input  logic    snoop_done_i,
  output thr_st_e st_o,
  output logic    snoop_busy_o
);
  thr_st_e st_q, st_d;
  logic    smi_arm_q, smi_arm_d;
  thr_st_e deep_st;

  assign deep_st = sleep_deep_i ? ST_C4 : ST_C2;

  always_comb begin
    st_d      = st_q;
    smi_arm_d = smi_arm_q;
    if (thr_rst_i) begin
      st_d      = ST_C0;
      smi_arm_d = 1'b0;
    end else begin
      case (st_q)
        ST_C0: begin
          if (rsm_i && smi_arm_q) begin
            st_d      = rsm_halt_i ? ST_C1 : ST_C0;
            smi_arm_d = 1'b0;
          end else if (sleep_req_i) st_d = deep_st;
          else if (halt_i)          st_d = ST_C1;
        end
        ST_C1: begin
          if (smi_i || wake_i) begin
            st_d = ST_C0;
            if (smi_i) smi_arm_d = 1'b1;
          end else if (sleep_req_i) st_d = deep_st;
          else if (stpclk_i)        st_d = ST_C1_STP;
          else if (snoop_req_i)     st_d = ST_C1_SNP;
        end
        ST_C2, ST_C4: if (smi_i || wake_i) st_d = ST_C0;
        ST_C1_STP:    if (!stpclk_i) st_d = ST_C1;
        ST_C1_SNP:    if (snoop_done_i) st_d = ST_C1;
        default:      st_d = ST_C0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_C0;
      smi_arm_q <= 1'b0;
    end else begin
      st_q      <= st_d;
      smi_arm_q <= smi_arm_d;
    end
  end

  assign st_o         = st_q;
  assign snoop_busy_o = (st_q == ST_C1_SNP);

  p_thr_rst_c0_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    thr_rst_i |=> st_q == ST_C0);
  p_c1_wake_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_C1 && (smi_i || wake_i)) |=> st_q == ST_C0);
  p_stp_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_C1_STP && stpclk_i && !thr_rst_i) |=> st_q == ST_C1_STP);
  p_snp_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_C1_SNP && !snoop_done_i && !thr_rst_i) |=> st_q == ST_C1_SNP);
  p_deep_src_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(st_q inside {ST_C0, ST_C1}) |=>
      (!(st_q inside {ST_C2, ST_C4}) || st_q == $past(st_q)));
endmodule

// File: rtl/pkg_resolve.sv
module pkg_resolve
  import cstate_pkg::*;
#(
  parameter int NT = 2
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  thr_st_e st_i [NT],
  output pkg_st_e pkg_o
);
  pkg_st_e min_d, pkg_q;

  always_comb begin
    min_d = PK_C4;
    for (int i = 0; i < NT; i++)
      if (depth_of(st_i[i]) < min_d) min_d = depth_of(st_i[i]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pkg_q <= PK_C0;
    else         pkg_q <= min_d;
  end

  assign pkg_o = pkg_q;

  p_pkg_c0_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i[0] == ST_C0) |=> pkg_q == PK_C0);
  p_pkg_c4_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkg_q == PK_C4) |-> $past(st_i[0] == ST_C4 && st_i[NT-1] == ST_C4));
endmodule

// File: rtl/cstate_coord.sv
module cstate_coord
  import cstate_pkg::*;
#(
  parameter int NT = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NT-1:0]   thr_rst_i,
  input  logic [NT-1:0]   halt_i,
  input  logic [NT-1:0]   sleep_req_i,
  input  logic [NT-1:0]   sleep_deep_i,
  input  logic [NT-1:0]   smi_i,
  input  logic [NT-1:0]   init_i,
  input  logic [NT-1:0]   nmi_i,
  input  logic [NT-1:0]   intr_i,
  input  logic [NT-1:0]   intmsg_i,
  input  logic [NT-1:0]   rsm_i,
  input  logic [NT-1:0]   rsm_halt_i,
  input  logic            stpclk_i,
  input  logic            snoop_req_i,
  input  logic            snoop_done_i,
  output logic [3*NT-1:0] thr_state_o,
  output logic [1:0]      pkg_state_o,
  output logic [NT-1:0]   snoop_busy_o
);
  localparam int ST_W = 3;

  thr_st_e st [NT];
  pkg_st_e pkg;

  for (genvar i = 0; i < NT; i++) begin : g_thr
    logic wake;
    assign wake = init_i[i] | nmi_i[i] | intr_i[i] | intmsg_i[i];

    thread_fsm u_fsm (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .thr_rst_i    (thr_rst_i[i]),
      .halt_i       (halt_i[i]),
      .sleep_req_i  (sleep_req_i[i]),
      .sleep_deep_i (sleep_deep_i[i]),
      .smi_i        (smi_i[i]),
      .wake_i       (wake),
      .rsm_i        (rsm_i[i]),
      .rsm_halt_i   (rsm_halt_i[i]),
      .stpclk_i     (stpclk_i),
      .snoop_req_i  (snoop_req_i),
      .snoop_done_i (snoop_done_i),
      .st_o         (st[i]),
      .snoop_busy_o (snoop_busy_o[i])
    );

    assign thr_state_o[i*ST_W +: ST_W] = st[i];
  end

  pkg_resolve #(.NT(NT)) u_res (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .st_i   (st),
    .pkg_o  (pkg)
  );

  assign pkg_state_o = pkg;
endmodule

// File: tb/cstate_coord_test.sv
`timescale 1ns/1ps
module cstate_coord_test;
  localparam int NT  = 2;
  localparam time CLK = 20ns;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [NT-1:0] thr_rst, halt, sleep_req, sleep_deep, smi, init, nmi, intr, intmsg, rsm, rsm_halt;
  logic stpclk, snoop_req, snoop_done;
  logic [3*NT-1:0] thr_state;
  logic [1:0] pkg_state;
  logic [NT-1:0] snoop_busy;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK/2) clk = ~clk;

  cstate_coord #(.NT(NT)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .thr_rst_i(thr_rst), .halt_i(halt),
    .sleep_req_i(sleep_req), .sleep_deep_i(sleep_deep), .smi_i(smi),
    .init_i(init), .nmi_i(nmi), .intr_i(intr), .intmsg_i(intmsg),
    .rsm_i(rsm), .rsm_halt_i(rsm_halt), .stpclk_i(stpclk),
    .snoop_req_i(snoop_req), .snoop_done_i(snoop_done),
    .thr_state_o(thr_state), .pkg_state_o(pkg_state), .snoop_busy_o(snoop_busy)
  );

  function automatic int st(int t);
    return int'(thr_state[t*3 +: 3]);
  endfunction

  // spec: shallowest level, sub-states 4/5 count as halted
  function automatic int lvl(int s);
    return (s >= 4) ? 1 : s;
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic idle();
    thr_rst = '0; halt = '0; sleep_req = '0; sleep_deep = '0; smi = '0;
    init = '0; nmi = '0; intr = '0; intmsg = '0; rsm = '0; rsm_halt = '0;
    stpclk = 1'b0; snoop_req = 1'b0; snoop_done = 1'b0;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic reset_threads();
    idle(); thr_rst = '1; step(); idle(); step();
  endtask

  // cmd: 1 halt, 2 sleep level 2, 3 sleep level 4
  task automatic put_cmd(int t, int cmd);
    if (cmd == 1) halt[t] = 1'b1;
    if (cmd >= 2) begin sleep_req[t] = 1'b1; sleep_deep[t] = (cmd == 3); end
  endtask

  task automatic t_reset();
    chk("R1 thread0 in reset", st(0), 0);
    chk("R1 pkg in reset", int'(pkg_state), 0);
    rst_ni = 1'b1;
    step();
    chk("R1 thread1 after reset", st(1), 0);
    chk("R1 snoop flags after reset", int'(snoop_busy), 0);
  endtask

  task automatic t_halt_wake();
    reset_threads();
    nmi[0] = 1'b1; step(); idle();
    chk("R4 wake in C0 ignored", st(0), 0);
    halt[0] = 1'b1; step(); idle();
    chk("R2 halt gives C1", st(0), 1);
    chk("R2 other thread untouched", st(1), 0);
    intmsg[0] = 1'b1; step(); idle();
    chk("R4 msg wakes C1", st(0), 0);
    halt[1] = 1'b1; step(); idle();
    init[1] = 1'b1; step(); idle();
    chk("R4 init wakes C1", st(1), 0);
  endtask

  task automatic t_deep();
    reset_threads();
    sleep_req[0] = 1'b1; halt[0] = 1'b1; step(); idle();
    chk("R3 sleep beats halt", st(0), 2);
    sleep_req[0] = 1'b1; sleep_deep[0] = 1'b1; halt[0] = 1'b1; step(); idle();
    chk("R3 requests ignored in C2", st(0), 2);
    intr[0] = 1'b1; step(); idle();
    chk("R4 intr wakes C2", st(0), 0);
    halt[0] = 1'b1; step(); idle();
    sleep_req[0] = 1'b1; sleep_deep[0] = 1'b1; step(); idle();
    chk("R3 C1 to C4", st(0), 3);
    smi[0] = 1'b1; step(); idle();
    chk("R4 smi wakes C4", st(0), 0);
  endtask

  task automatic t_thr_rst();
    reset_threads();
    thr_rst[0] = 1'b1; halt[0] = 1'b1; step(); idle();
    chk("R5 reset beats halt", st(0), 0);
    put_cmd(0, 3); step(); idle();
    thr_rst[0] = 1'b1; step(); idle();
    chk("R5 reset from C4", st(0), 0);
    halt[0] = 1'b1; step(); idle();
    snoop_req = 1'b1; step(); idle();
    thr_rst[0] = 1'b1; step(); idle();
    chk("R5 reset from snoop", st(0), 0);
    chk("R7 flag drops with reset", int'(snoop_busy), 0);
  endtask

  task automatic t_stpclk();
    reset_threads();
    halt[0] = 1'b1; step(); idle();
    stpclk = 1'b1; step();
    chk("R6 stop-clock from C1", st(0), 4);
    chk("R6 running thread ignores", st(1), 0);
    nmi[0] = 1'b1; step(); nmi[0] = 1'b0;
    chk("R6 wake ignored while stopped", st(0), 4);
    step();
    chk("R9 pkg sees running thread", int'(pkg_state), 0);
    stpclk = 1'b0; step();
    chk("R6 release returns to C1", st(0), 1);
  endtask

  task automatic t_snoop();
    reset_threads();
    halt[0] = 1'b1; step(); idle();
    snoop_req = 1'b1; step(); idle();
    chk("R7 snoop sub-state", st(0), 5);
    chk("R7 flag high only thread0", int'(snoop_busy), 1);
    step(); step();
    chk("R7 held without done", st(0), 5);
    snoop_done = 1'b1; step(); idle();
    chk("R7 done returns to C1", st(0), 1);
    chk("R7 flag low after done", int'(snoop_busy), 0);
  endtask

  task automatic t_smi_rsm();
    reset_threads();
    rsm[0] = 1'b1; rsm_halt[0] = 1'b1; step(); idle();
    chk("R8 unarmed resume ignored", st(0), 0);
    halt[0] = 1'b1; step(); idle();
    smi[0] = 1'b1; step(); idle();
    chk("R8 smi wakes", st(0), 0);
    rsm[0] = 1'b1; rsm_halt[0] = 1'b1; step(); idle();
    chk("R8 resume to halt", st(0), 1);
    smi[0] = 1'b1; step(); idle();
    rsm[0] = 1'b1; step(); idle();
    chk("R8 resume to run", st(0), 0);
    rsm[0] = 1'b1; rsm_halt[0] = 1'b1; step(); idle();
    chk("R8 resume disarmed", st(0), 0);
  endtask

  task automatic t_priority();
    reset_threads();
    halt[0] = 1'b1; step(); idle();
    nmi[0] = 1'b1; sleep_req[0] = 1'b1; stpclk = 1'b1; snoop_req = 1'b1; step(); idle();
    chk("R10 wake first", st(0), 0);
    halt[0] = 1'b1; step(); idle();
    sleep_req[0] = 1'b1; stpclk = 1'b1; snoop_req = 1'b1; step(); idle();
    chk("R10 sleep before stop-clock", st(0), 2);
    intr[0] = 1'b1; step(); idle();
    halt[0] = 1'b1; step(); idle();
    stpclk = 1'b1; snoop_req = 1'b1; step(); snoop_req = 1'b0;
    chk("R10 stop-clock before snoop", st(0), 4);
    stpclk = 1'b0; step();
    chk("R10 back to C1", st(0), 1);
  endtask

  task automatic t_pkg_pairs();
    for (int a = 0; a < 4; a++) begin
      for (int b = 0; b < 4; b++) begin
        reset_threads();
        put_cmd(0, a); put_cmd(1, b); step(); idle();
        chk($sformatf("R3 pair %0d/%0d thread0", a, b), st(0), a);
        chk($sformatf("R3 pair %0d/%0d thread1", a, b), st(1), b);
        step();
        chk($sformatf("R9 pkg for %0d/%0d", a, b), int'(pkg_state),
            (lvl(a) < lvl(b)) ? lvl(a) : lvl(b));
      end
    end
    // sub-state mixed with deeper sleep
    reset_threads();
    halt[0] = 1'b1; put_cmd(1, 3); step(); idle();
    snoop_req = 1'b1; step(); idle();
    step();
    chk("R9 snoop counts as C1", int'(pkg_state), 1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    idle();
    repeat (3) step();
    t_reset();
    t_halt_wake();
    t_deep();
    t_thr_rst();
    t_stpclk();
    t_snoop();
    t_smi_rsm();
    t_priority();
    t_pkg_pairs();
    finish_run();
  end

  initial begin
    #(CLK * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule